// File: doc/BRIEF.md
# Programmable Bit-Mux Serial Link Transmitter

This block turns one parallel pixel word per pixel period into seven-bit serial frames on up to four data lanes. Each of the seven bit slots of every lane has its own programmable selector that names which bit of the incoming word it carries. An eighth lane sends a fixed clock pattern once per pixel period. The block runs on the bit-rate clock, and one pixel period is seven of its cycles.

Words enter through a valid/ready port. The block raises `pix_ready` for one cycle in seven, in the last bit cycle of the frame being sent. A word is taken when `pix_valid` and `pix_ready` are both high on the same edge. The source cannot stall the line. If no word is offered when ready is high, the data lanes send a frame of zeros for that period and the clock lane keeps running.

Static controls set the following: the lane enables for two output channels, single or dual channel mode, channel swap, a global interface enable, and a serialization enable. Software writes the configuration first and raises the serialization enable last. In dual mode the second channel copies the first channel's lane data, each lane gated by its own enable.

Top module: `lvds_lane_mux_ser`

## Requirements
- R1: During and after reset, with `ser_en` low, `pix_ready` is 0 and every data and clock output is 0.
- R2: Lane l, slot s takes its selector from `sel_idx[5*(7*l+s) +: 5]`. That slot carries bit `pix_data[index]` of the accepted word. An index of 28 or above gives 0.
- R3: In the seven cycles after the acceptance edge, each lane sends slot 6 first and slot 0 last, one bit per cycle.
- R4: While `ser_en` is high, `pix_ready` is high in exactly one cycle of every seven: the cycle that shows slot 0. If `pix_valid` is low at that edge, the next frame is all zeros on every data lane.
- R5: Every pixel period the clock lane sends 1,1,0,0,0,1,1, in the same cycles as slots 6 down to 0.
- R6: While `ser_en` is low, nothing shifts, `pix_ready` is 0 and all outputs are 0. When `ser_en` rises, `pix_ready` is high in that first cycle.
- R7: While `intf_en` is low, all data and clock outputs are 0.
- R8: `lane_en[3:0]` enables the channel-A lanes and `lane_en[7:4]` enables the channel-B lanes. A disabled lane outputs 0.
- R9: With `dual_mode` = 0, channel B outputs are all 0 and only the channel-A clock runs. With `dual_mode` = 1, channel B sends the same lane bits and clock as channel A, gated by its own lane enables.
- R10: With `ch_swap` = 1, the channel-A and channel-B output pins are exchanged.
- R11: A change to `sel_idx` after a word is accepted does not alter that word's frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Serialization enable |
| intf_en | input | 1 | Global interface drive enable |
| dual_mode | input | 1 | 1 = both channels active |
| ch_swap | input | 1 | Exchange channel A and B pins |
| lane_en | input | 8 | Lane enables, [3:0] channel A, [7:4] channel B |
| sel_idx | input | 140 | Per-lane, per-slot 5-bit source bit indices |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Word taken on this edge if valid |
| pix_data | input | 28 | Parallel pixel word |
| a_data | output | 4 | Channel A serial data lanes |
| a_clk | output | 1 | Channel A clock lane |
| b_data | output | 4 | Channel B serial data lanes |
| b_clk | output | 1 | Channel B clock lane |

## Verification
The bench uses a scrambled selector map, a reversed map and out-of-range indices. A design that sent LSB first, or indexed slots off by one, would show bit-reversed or rotated frames on every lane. The bench leaves `pix_valid` low at a ready cycle to catch a design that repeats the old word instead of sending zeros. It rewrites the selectors partway through a frame to catch a design that muxes at shift time rather than at load time. It drops and restores `ser_en` to catch a slot counter that does not restart cleanly, which would misalign both the ready pulse and the clock pattern.

// File: rtl/lvds_mux_pkg.sv
package lvds_mux_pkg;
  localparam int SLOTS = 7;
  localparam logic [SLOTS-1:0] CLK_PATTERN = 7'b1100011;
endpackage

// File: rtl/lvds_bit_sel.sv
module lvds_bit_sel #(
  parameter int SRC_W = 28,
  parameter int IDX_W = 5,
  parameter int SLOTS = 7
) (
  input  logic [SRC_W-1:0]       word,
  input  logic [SLOTS*IDX_W-1:0] sel,
  output logic [SLOTS-1:0]       bits
);
  localparam int EXT_W = 1 << IDX_W;

  logic [EXT_W-1:0] ext;

  // indices past the source width land on zero padding
  always_comb begin
    ext = '0;
    ext[SRC_W-1:0] = word;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    assign bits[s] = ext[sel[s*IDX_W +: IDX_W]];
  end
endmodule

// File: rtl/lvds_slot_timer.sv
module lvds_slot_timer #(
  parameter int SLOTS = 7,
  localparam int CW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  output logic [CW-1:0] slot,
  output logic          last
);
  localparam logic [CW-1:0] LAST_SLOT = CW'(SLOTS - 1);

  assign last = (slot == LAST_SLOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     slot <= LAST_SLOT;
    else if (!run)  slot <= LAST_SLOT;
    else if (last)  slot <= '0;
    else            slot <= slot + 1'b1;
  end

  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> (slot == $past(slot) + 1'b1)); // R4
endmodule

// File: rtl/lvds_lane_shift.sv
module lvds_lane_shift #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         dout
);
  logic [W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sh <= '0;
    else if (clear)  sh <= '0;
    else if (load)   sh <= din;
    else if (shift)  sh <= {sh[W-2:0], 1'b0};
  end

  assign dout = sh[W-1];

  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !clear) |=> (dout == $past(din[W-1]))); // R3
endmodule

// File: rtl/lvds_lane_mux_ser.sv
module lvds_lane_mux_ser
  import lvds_mux_pkg::*;
#(
  parameter int SRC_W = 28,
  parameter int LANES = 4,
  parameter int IDX_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ser_en,
  input  logic                         intf_en,
  input  logic                         dual_mode,
  input  logic                         ch_swap,
  input  logic [2*LANES-1:0]           lane_en,
  input  logic [LANES*SLOTS*IDX_W-1:0] sel_idx,
  input  logic                         pix_valid,
  output logic                         pix_ready,
  input  logic [SRC_W-1:0]             pix_data,
  output logic [LANES-1:0]             a_data,
  output logic                         a_clk,
  output logic [LANES-1:0]             b_data,
  output logic                         b_clk
);
  localparam int LANE_CFG_W = SLOTS * IDX_W;
  localparam int CW = $clog2(SLOTS);

  logic [CW-1:0]    slot;
  logic             last;
  logic             load;
  logic             shift;
  logic             fire;
  logic [LANES-1:0] lane_bits;
  logic             clk_bit;
  logic             drive;
  logic [LANES-1:0] chan_a, chan_b;
  logic             ck_a, ck_b;

  lvds_slot_timer #(.SLOTS(SLOTS)) i_timer (
    .clk(clk), .rst_n(rst_n), .run(ser_en), .slot(slot), .last(last)
  );

  assign pix_ready = ser_en && last;
  assign fire      = pix_valid && pix_ready;
  assign load      = ser_en && last;
  assign shift     = ser_en && !last;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] picked;
    logic [SLOTS-1:0] frame;

    lvds_bit_sel #(.SRC_W(SRC_W), .IDX_W(IDX_W), .SLOTS(SLOTS)) i_sel (
      .word(pix_data),
      .sel (sel_idx[l*LANE_CFG_W +: LANE_CFG_W]),
      .bits(picked)
    );

    // an empty slot in the stream becomes an all-zero frame
    assign frame = fire ? picked : '0;

    lvds_lane_shift #(.W(SLOTS)) i_shift (
      .clk(clk), .rst_n(rst_n), .clear(!ser_en), .load(load),
      .shift(shift), .din(frame), .dout(lane_bits[l])
    );
  end

  lvds_lane_shift #(.W(SLOTS)) i_clk_lane (
    .clk(clk), .rst_n(rst_n), .clear(!ser_en), .load(load),
    .shift(shift), .din(CLK_PATTERN), .dout(clk_bit)
  );

  assign drive  = ser_en && intf_en;
  assign chan_a = lane_bits & lane_en[LANES-1:0] & {LANES{drive}};
  assign chan_b = lane_bits & lane_en[2*LANES-1:LANES] & {LANES{drive && dual_mode}};
  assign ck_a   = clk_bit && drive;
  assign ck_b   = clk_bit && drive && dual_mode;

  assign a_data = ch_swap ? chan_b : chan_a;
  assign b_data = ch_swap ? chan_a : chan_b;
  assign a_clk  = ch_swap ? ck_b : ck_a;
  assign b_clk  = ch_swap ? ck_a : ck_b;

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !(ser_en && intf_en) |-> (a_data == '0 && b_data == '0 && !a_clk && !b_clk)); // R7
  AST_B_IDLE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!dual_mode && !ch_swap) |-> (b_data == '0 && !b_clk)); // R9
  AST_READY_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && ser_en) |=> !pix_ready); // R4
endmodule

// File: tb/test_lvds_lane_mux_ser.sv
module test_lvds_lane_mux_ser;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] PAT = 7'b1100011;
  // {ch_swap, dual_mode, lane_en[7:0], word[27:0]}
  localparam logic [37:0] VEC [6] = '{
    {1'b0, 1'b0, 8'h0F, 28'h0A5C3F1},
    {1'b0, 1'b0, 8'h07, 28'hFFFFFFF},
    {1'b0, 1'b1, 8'hFF, 28'h1234567},
    {1'b0, 1'b1, 8'h5A, 28'h8E1D2B4},
    {1'b1, 1'b1, 8'hF3, 28'h3C96A5F},
    {1'b1, 1'b0, 8'h0F, 28'h7F00E11}
  };

  logic clk = 1'b0;
  logic rst_n, ser_en, intf_en, dual_mode, ch_swap, pix_valid, pix_ready;
  logic [7:0] lane_en;
  logic [139:0] sel_idx;
  logic [27:0] pix_data;
  logic [3:0] a_data, b_data;
  logic a_clk, b_clk;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lvds_lane_mux_ser i_lvds_lane_mux_ser (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .intf_en(intf_en),
    .dual_mode(dual_mode), .ch_swap(ch_swap), .lane_en(lane_en),
    .sel_idx(sel_idx), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .a_data(a_data), .a_clk(a_clk),
    .b_data(b_data), .b_clk(b_clk)
  );

  task automatic check(input string tag, input logic [10:0] act, input logic [10:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (ready,a_data,a_clk,b_data,b_clk)", tag, act, exp);
    end
  endtask

  function automatic logic [10:0] observed();
    return {pix_ready, a_data, a_clk, b_data, b_clk};
  endfunction

  // send one word (or an empty slot when v=0) and check all seven bit cycles
  task automatic send(input logic [27:0] w, input logic v, input logic perturb, input string tag);
    logic [139:0] snap;
    logic [27:0] ew;
    pix_data = w;
    pix_valid = v;
    while (!pix_ready) @(negedge clk);
    snap = sel_idx;
    ew = v ? w : 28'h0;
    @(negedge clk);
    pix_valid = 1'b0;
    for (int k = 0; k < 7; k++) begin
      logic [3:0] lanes, ea, eb;
      logic drv, ca, cb;
      if (perturb && k == 1) sel_idx = ~sel_idx;
      for (int l = 0; l < 4; l++) begin
        logic [4:0] idx;
        idx = snap[(l*7 + 6 - k)*5 +: 5];
        lanes[l] = (idx < 5'd28) ? ew[idx] : 1'b0;
      end
      drv = ser_en && intf_en;
      ea = lanes & lane_en[3:0] & {4{drv}};
      eb = dual_mode ? (lanes & lane_en[7:4] & {4{drv}}) : 4'h0;
      ca = PAT[6-k] && drv;
      cb = dual_mode && ca;
      if (ch_swap) check(tag, observed(), {(k == 6), eb, cb, ea, ca});
      else         check(tag, observed(), {(k == 6), ea, ca, eb, cb});
      if (k < 6) @(negedge clk);
    end
    if (perturb) sel_idx = snap;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ser_en = 1'b0; intf_en = 1'b0; dual_mode = 1'b0; ch_swap = 1'b0;
    lane_en = 8'h0F; pix_valid = 1'b0; pix_data = '0;
    for (int i = 0; i < 28; i++) sel_idx[i*5 +: 5] = 5'((i * 3) % 28);
    repeat (3) @(negedge clk);
    check("R1 in reset", observed(), 11'h0);
    rst_n = 1'b1;
    intf_en = 1'b1;
    pix_valid = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after reset, ser_en low", observed(), 11'h0);
    ser_en = 1'b1;
    #1;
    check("R6 ready in first enabled cycle", {pix_ready, 10'h0}, {1'b1, 10'h0});

    // table of configurations and words: R2 R3 R5 R8 R9 R10
    for (int n = 0; n < 6; n++) begin
      ch_swap = VEC[n][37];
      dual_mode = VEC[n][36];
      lane_en = VEC[n][35:28];
      send(VEC[n][27:0], 1'b1, 1'b0, "R2/R3/R5/R8/R9/R10 table");
    end

    // R2: reversed map with out-of-range indices
    ch_swap = 1'b0; dual_mode = 1'b1; lane_en = 8'hFF;
    for (int i = 0; i < 28; i++) sel_idx[i*5 +: 5] = 5'(27 - i);
    sel_idx[6*5 +: 5] = 5'd31;
    sel_idx[14*5 +: 5] = 5'd28;
    send(28'hFFFFFFF, 1'b1, 1'b0, "R2 out-of-range index");
    send(28'h5A5A5A5, 1'b1, 1'b0, "R2 reversed map");

    // R4: empty slot sends zero frame, clock continues
    send(28'hFFFFFFF, 1'b0, 1'b0, "R4 no word offered");

    // R11: selectors rewritten mid-frame
    send(28'h6B3C1E9, 1'b1, 1'b1, "R11 selector change mid-word");

    // R7: interface disabled
    intf_en = 1'b0;
    send(28'hFFFFFFF, 1'b1, 1'b0, "R7 interface off");
    intf_en = 1'b1;

    // R6: serialization off holds everything quiet
    @(negedge clk);
    @(negedge clk);
    ser_en = 1'b0;
    pix_valid = 1'b1;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      check("R6 ser_en low", observed(), 11'h0);
    end
    ser_en = 1'b1;
    #1;
    check("R6 ready after re-enable", {pix_ready, 10'h0}, {1'b1, 10'h0});
    send(28'h0F0F0F0, 1'b1, 1'b0, "R6 restart frame");
    send(28'h1111111, 1'b1, 1'b0, "R4 back-to-back");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule